// File: doc/BRIEF.md
# Address Window Translation Unit

This block steers bus requests through programmable address windows. Two request sources share it: the processor and PCI bus-master DMA. Each source has its own set of four windows. A window is described by a base, a mask and a remap value. The mask defines a power-of-two region; the remap value supplies the upper part of the translated address and, in its lowest bit, the destination code.

For each accepted request, the unit picks the lowest-numbered window of the issuing set whose region contains the address. One cycle later it returns the translated address and one of three destination ports: DDR memory, PCI or local I/O. If no window contains the address, it flags a miss instead.

The 24 window registers are written and read over a flat 64-bit register interface. Reads are combinational. All offsets outside the window registers read as zero.

Top module: `addr_window_xlate`

## Requirements
- R1: Every window register is 64 bits wide, writable and readable. The offset of window w is as follows: processor base 0x00+8w, mask 0x20+8w, remap 0x40+8w; DMA base 0x60+8w, mask 0x80+8w, remap 0xA0+8w.
- R2: Every other offset in the 0x180-byte space reads as zero and ignores writes. This covers offsets 0xC0 and above, and any offset with nonzero bits [2:0].
- R3: After reset, processor window 0 has base 0, mask 0xFFFFFFFF_F0000000 and remap 0, which is DDR. Processor window 1 has base 0x10000000, the same mask, and remap 0x10000001, which is PCI. All other windows have base all ones and mask all ones.
- R4: A window hits when (addr & mask) == (base & mask), so its size is ~mask + 1.
- R5: On a hit, the translated address is (remap & mask & ~1) | (addr & ~mask).
- R6: res_port uses the encoding 0 = DDR, 1 = PCI, 2 = local I/O, 3 = none. Remap bit 0 equal to 0 gives DDR for either set. Remap bit 0 equal to 1 gives PCI for the processor set and local I/O for the DMA set.
- R7: When several windows of the issuing set hit, the lowest-numbered one is used.
- R8: When no window of the issuing set hits, the result has res_miss=1, res_port=3 and res_addr=0.
- R9: A window whose base bit 0 is 1 never hits.
- R10: A register write affects translation from the next cycle on. A request accepted in the same cycle as the write still uses the old value.
- R11: A request that is accepted (req_valid and req_ready) yields res_valid one cycle later. req_ready equals !res_valid || res_ready. A result held while res_ready is low keeps all its fields stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 9 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for cfg_addr, combinational |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_src | input | 1 | Issuing set: 0 processor, 1 DMA |
| req_addr | input | 64 | Request address |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumed when high together with res_valid |
| res_addr | output | 64 | Translated address, 0 on miss |
| res_port | output | 2 | Destination: 0 DDR, 1 PCI, 2 local I/O, 3 none |
| res_miss | output | 1 | No window hit |

## Verification
Register read data is combinational, so the bench samples it 1 ns after it changes cfg_addr, and samples it after a write once the writing edge has passed. A translation result is due at the first rising edge after the request is accepted. The bench drives each request at a falling edge and samples the result at the next falling edge, where the result stands alone. The same-cycle write case checks that a write landing on the accepting edge does not reach that result but does reach the next one. The backpressure case samples across several falling edges while res_ready is low, and then samples the edge at which the held result drains and a new request enters.

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int AW     = 64,
  parameter int CFG_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_src,
  input  logic [AW-1:0]     req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [AW-1:0]     res_addr,
  output logic [1:0]        res_port,
  output logic              res_miss
);
  localparam int NWIN  = 4;
  localparam int NSLOT = 2 * NWIN;
  localparam logic [AW-1:0] BOOT_MASK = {{(AW-28){1'b1}}, 28'h0};
  localparam logic [AW-1:0] WIN1_BASE = AW'(64'h1000_0000);
  localparam logic [1:0] P_DDR = 2'd0, P_PCI = 2'd1, P_LIO = 2'd2, P_NONE = 2'd3;

  logic [AW-1:0] base_q  [NSLOT];
  logic [AW-1:0] mask_q  [NSLOT];
  logic [AW-1:0] remap_q [NSLOT];

  // register decode: offset[7:5] picks one of six groups, offset[4:3] the window
  logic [2:0] grp;
  logic       in_map, grp_dma;
  logic [1:0] kind;
  logic [2:0] cslot;

  assign grp     = cfg_addr[7:5];
  assign in_map  = (cfg_addr[2:0] == 3'd0) && (cfg_addr[CFG_AW-1:8] == '0) && (grp < 3'd6);
  assign grp_dma = (grp >= 3'd3);
  assign kind    = grp_dma ? 2'(grp - 3'd3) : grp[1:0];
  assign cslot   = {grp_dma, cfg_addr[4:3]};

  always_comb begin
    cfg_rdata = '0;
    if (in_map) begin
      case (kind)
        2'd0:    cfg_rdata = base_q[cslot];
        2'd1:    cfg_rdata = mask_q[cslot];
        default: cfg_rdata = remap_q[cslot];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) begin
        base_q[s]  <= '1;
        mask_q[s]  <= '1;
        remap_q[s] <= '0;
      end
      base_q[0]  <= '0;
      mask_q[0]  <= BOOT_MASK;
      remap_q[0] <= '0;
      base_q[1]  <= WIN1_BASE;
      mask_q[1]  <= BOOT_MASK;
      remap_q[1] <= WIN1_BASE | AW'(1);
    end else if (cfg_wr && in_map) begin
      case (kind)
        2'd0:    base_q[cslot]  <= cfg_wdata;
        2'd1:    mask_q[cslot]  <= cfg_wdata;
        default: remap_q[cslot] <= cfg_wdata;
      endcase
    end
  end

  // per-window hit, base bit 0 disables a window
  logic [NSLOT-1:0] win_hit;
  for (genvar s = 0; s < NSLOT; s++) begin : g_hit
    assign win_hit[s] = !base_q[s][0] && (((req_addr ^ base_q[s]) & mask_q[s]) == '0);
  end

  logic       any_hit;
  logic [1:0] sel;
  always_comb begin
    any_hit = 1'b0;
    sel     = 2'd0;
    for (int w = NWIN - 1; w >= 0; w--) begin
      if (win_hit[{req_src, 2'(w)}]) begin
        any_hit = 1'b1;
        sel     = 2'(w);
      end
    end
  end

  logic [2:0]    rslot;
  logic [AW-1:0] nx_addr;
  logic [1:0]    nx_port;
  assign rslot   = {req_src, sel};
  assign nx_addr = any_hit ? ((remap_q[rslot] & mask_q[rslot] & ~AW'(1)) | (req_addr & ~mask_q[rslot])) : '0;
  assign nx_port = !any_hit ? P_NONE :
                   !remap_q[rslot][0] ? P_DDR :
                   req_src ? P_LIO : P_PCI;

  assign req_ready = !res_valid || res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_port  <= P_NONE;
      res_miss  <= 1'b0;
    end else if (req_valid && req_ready) begin
      res_valid <= 1'b1;
      res_addr  <= nx_addr;
      res_port  <= nx_port;
      res_miss  <= !any_hit;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  assert_accept_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> res_valid);

  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_port) && $stable(res_miss));

  assert_miss_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_miss |-> res_port == P_NONE && res_addr == '0);

  assert_hit_has_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_miss |-> res_port != P_NONE);

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_addr[2:0] == 3'd0 && cfg_addr < CFG_AW'(9'h0C0)
    |=> (cfg_addr != $past(cfg_addr)) || (cfg_rdata == $past(cfg_wdata)));

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[2:0] != 3'd0 || cfg_addr >= CFG_AW'(9'h0C0)) |-> cfg_rdata == '0);
endmodule

// File: tb/addr_window_xlate_tb.sv
module addr_window_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [8:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0, req_ready, req_src = 1'b0;
  logic [63:0] req_addr = '0;
  logic        res_valid, res_ready = 1'b1, res_miss;
  logic [63:0] res_addr;
  logic [1:0]  res_port;

  int total = 0, bad = 0;
  bit done = 0;

  logic [63:0] sb [8];
  logic [63:0] sm [8];
  logic [63:0] sr [8];

  addr_window_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_src(req_src), .req_addr(req_addr),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_port(res_port), .res_miss(res_miss)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] shadow_rd(input int off);
    int g, s;
    if (off[2:0] != 0 || off >= 'hC0) return '0;
    g = off / 32;
    s = (g >= 3 ? 4 : 0) + (off / 8) % 4;
    case (g % 3)
      0: return sb[s];
      1: return sm[s];
      default: return sr[s];
    endcase
  endfunction

  function automatic void model(input logic src, input logic [63:0] a,
                                output logic miss, output logic [1:0] port, output logic [63:0] xa);
    miss = 1'b1; port = 2'd3; xa = '0;
    for (int w = 0; w < 4; w++) begin
      int i;
      i = (src ? 4 : 0) + w;
      if (!sb[i][0] && ((a & sm[i]) == (sb[i] & sm[i]))) begin
        miss = 1'b0;
        xa   = (sr[i] & sm[i] & ~64'h1) | (a & ~sm[i]);
        port = sr[i][0] ? (src ? 2'd2 : 2'd1) : 2'd0;
        break;
      end
    end
  endfunction

  task automatic wr(input int off, input logic [63:0] d);
    int g, s;
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 9'(off); cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    if (off[2:0] == 0 && off < 'hC0) begin
      g = off / 32;
      s = (g >= 3 ? 4 : 0) + (off / 8) % 4;
      case (g % 3)
        0: sb[s] = d;
        1: sm[s] = d;
        default: sr[s] = d;
      endcase
    end
  endtask

  task automatic rd_chk(input string tag, input int off);
    cfg_addr = 9'(off);
    #1;
    chk(tag, cfg_rdata, shadow_rd(off));
  endtask

  task automatic xlate(input string tag, input logic src, input logic [63:0] a);
    logic m; logic [1:0] p; logic [63:0] x;
    model(src, a, m, p, x);
    @(negedge clk);
    req_valid = 1'b1; req_src = src; req_addr = a; res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R11 valid"}, 64'(res_valid), 64'd1);
    chk({tag, " R8 miss"}, 64'(res_miss), 64'(m));
    chk({tag, " R6 port"}, 64'(res_port), 64'(p));
    chk({tag, " R5 addr"}, res_addr, x);
  endtask

  task automatic sweep(input string tag);
    for (int k = 0; k < 64; k++) begin
      logic [63:0] a;
      a = (64'(k) << 25) | ((64'(k) * 64'h0001_0357) & 64'h01FF_FFF8);
      xlate({tag, " R4 R7 cpu"}, 1'b0, a);
      xlate({tag, " R4 R7 dma"}, 1'b1, a);
    end
    xlate({tag, " R8 high"}, 1'b0, 64'h0000_0004_0000_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 8; s++) begin sb[s] = '1; sm[s] = '1; sr[s] = '0; end
    sb[0] = 64'h0;         sm[0] = 64'hFFFF_FFFF_F000_0000; sr[0] = 64'h0;
    sb[1] = 64'h1000_0000; sm[1] = 64'hFFFF_FFFF_F000_0000; sr[1] = 64'h1000_0001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset valid", 64'(res_valid), 64'd0);
    chk("R11 reset ready", 64'(req_ready), 64'd1);

    // R3 reset values and R2 empty offsets, all byte offsets
    for (int off = 0; off < 'h180; off++) rd_chk("R3 R2 reset read", off);

    // R3 boot map translation
    for (int k = 0; k < 16; k++) begin
      xlate("R3 boot cpu", 1'b0, 64'(k) * 64'h0400_0000 + 64'h88);
      xlate("R3 boot dma", 1'b1, 64'(k) * 64'h0400_0000 + 64'h88);
    end

    // R2 writes to empty offsets are ignored
    wr('hC0, '1); wr('h100, '1); wr('h178, '1); wr('h04, '1); wr('h23, '1); wr('hBF, '1);
    @(negedge clk);
    for (int off = 0; off < 'hC0; off += 8) rd_chk("R2 ignored write", off);
    xlate("R2 map intact", 1'b0, 64'h1234_5670);

    // R1 program both sets, read back
    wr('h10, 64'h4000_0000); wr('h30, 64'hFFFF_FFFF_C000_0000); wr('h50, 64'h4000_0001);
    wr('h18, 64'h0);         wr('h38, 64'hFFFF_FFFF_C000_0000); wr('h58, 64'h2_0000_0000);
    wr('h60, 64'h0);         wr('h80, 64'hFFFF_FFFF_FC00_0000); wr('hA0, 64'h1_0000_0000);
    wr('h68, 64'h0800_0000); wr('h88, 64'hFFFF_FFFF_F800_0000); wr('hA8, 64'h3000_0001);
    wr('h70, 64'h0);         wr('h90, 64'h0);                   wr('hB0, 64'h0);
    wr('h78, 64'h1);         wr('h98, 64'h0);                   wr('hB8, 64'h0);
    @(negedge clk);
    for (int off = 0; off < 'hC0; off += 8) rd_chk("R1 readback", off);

    sweep("programmed");

    // R9 disable processor window 0 via base bit 0
    wr('h00, 64'h1);
    xlate("R9 disabled win0", 1'b0, 64'h0000_0000_0123_4560);
    sweep("win0 off");
    wr('h00, 64'h0);

    // R10 write in the same cycle as request acceptance
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 9'h40; cfg_wdata = 64'h5000_0000;
    req_valid = 1'b1; req_src = 1'b0; req_addr = 64'h0123_4568;
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    chk("R10 old remap addr", res_addr, 64'h0123_4568);
    chk("R10 old remap port", 64'(res_port), 64'd0);
    sr[0] = 64'h5000_0000;
    xlate("R10 new remap", 1'b0, 64'h0123_4568);
    chk("R10 new remap addr", res_addr, 64'h5123_4568);

    // R11 backpressure
    @(negedge clk);
    res_ready = 1'b0; req_valid = 1'b1; req_src = 1'b0; req_addr = 64'h1000_0010;
    @(negedge clk);
    chk("R11 held valid", 64'(res_valid), 64'd1);
    chk("R11 ready low", 64'(req_ready), 64'd0);
    req_addr = 64'h20;
    @(negedge clk);
    chk("R11 held addr", res_addr, 64'h1000_0010);
    chk("R11 held port", 64'(res_port), 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next valid", 64'(res_valid), 64'd1);
    chk("R11 next addr", res_addr, 64'h5000_0020);
    @(negedge clk);
    chk("R11 drained", 64'(res_valid), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule